// File: doc/BRIEF.md
# Frame Heap Free-List Allocator

This block hands out and takes back fixed-size local frames kept on singly linked free lists. A small table of list heads (the allocation vector) sits in word-addressed memory at an aligned base; the size index of a request is merged into the low bits of that base to find the head word of its list. The two low bits of every head word are a tag, so one word says whether the list has a usable frame, is empty, forwards the request to another size list, or holds an undefined value.

An allocation follows the head, walking forwarding entries up to a set number of times. It then reads the chosen frame's link word, writes that word back unchanged so that any write-protect fault on the frame appears before the list is touched, and installs the successor as the new head. A release reads the size index from a header word a fixed distance below the frame, makes the frame the new head of that list and stores the previous head in the frame's link word. Every memory access goes through one registered request port with a one-cycle read latency. A failed allocation ends with a fault flag and the size index first requested.

Top module: `frame_pool_alloc`

## Requirements
- R1: An allocation of size index i first reads the word at AV_BASE with i placed in its low IW bits.
- R2: When the head word's tag (bits 1:0) is 0, the block returns that word as the frame address, and the head word then holds the frame's former link word (the word at the frame address).
- R3: During a successful allocation the frame's link word is written with its own value one request before the head word is written, and these are the only two writes.
- R4: A head tag of 1 (empty) ends the allocation with fault=1, fault_idx equal to the requested index, and no memory write.
- R5: A head tag of 3 (undefined) ends the allocation with fault=1, the requested index in fault_idx, and no memory write.
- R6: A head tag of 2 forwards the lookup to the size index held in bits IW+1:2 of that head word; a success takes the frame from, and updates the head of, the list finally reached, and a fault reports the index first requested.
- R7: At most HOP_LIMIT forwarding steps are followed; a forwarding tag met after HOP_LIMIT steps raises the fault with the requested index.
- R8: A release of frame f reads the size index j from bits IW-1:0 of the word at f-HDR_OFS, then writes f into head j and the previous head j into the word at f.
- R9: busy is high from the cycle after an accepted request until the end of the operation, done is a one-cycle pulse with busy low, and request inputs seen while busy have no effect.
- R10: If an allocation and a release are requested in the same idle cycle, only the allocation is carried out and the release is dropped.
- R11: After reset, busy, done, fault and the memory request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_go | input | 1 | Request an allocation (sampled when idle) |
| free_go | input | 1 | Request a release (sampled when idle) |
| size_idx_in | input | IW | Size index of an allocation |
| frame_in | input | W | Frame address to release |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Allocation failed (valid with done) |
| fault_idx | output | IW | Originally requested size index of a failed allocation |
| frame_out | output | W | Allocated frame address (valid with done, no fault) |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | W | Memory word address |
| mem_wdata | output | W | Memory write data |
| mem_rdata | input | W | Read data, valid the cycle after a read request |

## Verification
An allocation and a release can arrive in the same idle cycle; the bench raises both strobes together with a release candidate whose list is known to be empty, then judges that the allocated frame is the one at the head of the requested list and that the release's list still reads empty afterwards. It also pulses the release strobe and changes the size index in the middle of an allocation, then confirms the result is unaffected and that no further operation starts. Directed lists cover empty, undefined, forwarding chains at and beyond the hop limit, and a forwarding cycle; seeded random mixes of allocations and releases are compared against a list walk done by the bench on its own memory model.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_A_WAIT,
    S_A_TAG,
    S_A_SWAIT,
    S_A_SUCC,
    S_A_HEAD,
    S_F_WAIT,
    S_F_IDX,
    S_F_HWAIT,
    S_F_HEAD,
    S_F_LINK,
    S_FIN
  } fpa_state_e;

  typedef enum logic [1:0] {
    TAG_FRAME = 2'd0,
    TAG_EMPTY = 2'd1,
    TAG_REDIR = 2'd2,
    TAG_UNDEF = 2'd3
  } fpa_tag_e;

endpackage

// File: rtl/fpa_hop_ctr.sv
module fpa_hop_ctr #(
  parameter int unsigned HOP_LIMIT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic step,
  output logic at_limit
);
  localparam int CW = $clog2(HOP_LIMIT + 1) + 1;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else if (step)  cnt <= cnt + 1'b1;
  end

  assign at_limit = (cnt == CW'(HOP_LIMIT));

  // R7
  hop_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(HOP_LIMIT));

endmodule

// File: rtl/fpa_mem_port.sv
module fpa_mem_port #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         c_req,
  input  logic         c_we,
  input  logic [W-1:0] c_addr,
  input  logic [W-1:0] c_wdata,
  output logic         mem_req,
  output logic         mem_we,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_req   <= c_req;
      mem_we    <= c_req & c_we;
      mem_addr  <= c_addr;
      mem_wdata <= c_wdata;
    end
  end

  // R11
  we_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

endmodule

// File: rtl/frame_pool_alloc.sv
module frame_pool_alloc
  import fpa_pkg::*;
#(
  parameter int             W         = 12,
  parameter int             IW        = 4,
  parameter logic [W-1:0]   AV_BASE   = 12'h100,
  parameter int unsigned    HDR_OFS   = 4,
  parameter int unsigned    HOP_LIMIT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          alloc_go,
  input  logic          free_go,
  input  logic [IW-1:0] size_idx_in,
  input  logic [W-1:0]  frame_in,
  output logic          busy,
  output logic          done,
  output logic          fault,
  output logic [IW-1:0] fault_idx,
  output logic [W-1:0]  frame_out,
  output logic          mem_req,
  output logic          mem_we,
  output logic [W-1:0]  mem_addr,
  output logic [W-1:0]  mem_wdata,
  input  logic [W-1:0]  mem_rdata
);
  localparam logic [W-1:0] HDR_DIST = W'(HDR_OFS);

  fpa_state_e    state, nxt;
  logic [IW-1:0] cur_idx, orig_idx;
  logic [W-1:0]  frame_r, succ_r;
  logic          c_req, c_we;
  logic [W-1:0]  c_addr, c_wdata;
  logic          hop_clr, hop_step, hop_at_lim;
  fpa_tag_e      tag;
  logic [IW-1:0] redir_idx, hdr_idx;

  assign tag       = fpa_tag_e'(mem_rdata[1:0]);
  assign redir_idx = mem_rdata[IW+1:2];
  assign hdr_idx   = mem_rdata[IW-1:0];

  function automatic logic [W-1:0] av_addr(input logic [IW-1:0] idx);
    return AV_BASE | {{(W-IW){1'b0}}, idx};
  endfunction

  fpa_hop_ctr #(.HOP_LIMIT(HOP_LIMIT)) hop_i (
    .clk(clk), .rst(rst), .clr(hop_clr), .step(hop_step), .at_limit(hop_at_lim)
  );

  fpa_mem_port #(.W(W)) port_i (
    .clk(clk), .rst(rst),
    .c_req(c_req), .c_we(c_we), .c_addr(c_addr), .c_wdata(c_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always_comb begin
    nxt      = state;
    c_req    = 1'b0;
    c_we     = 1'b0;
    c_addr   = '0;
    c_wdata  = '0;
    hop_clr  = 1'b0;
    hop_step = 1'b0;
    case (state)
      S_IDLE: begin
        if (alloc_go) begin
          c_req = 1'b1; c_addr = av_addr(size_idx_in);
          hop_clr = 1'b1; nxt = S_A_WAIT;
        end else if (free_go) begin
          c_req = 1'b1; c_addr = frame_in - HDR_DIST;
          nxt = S_F_WAIT;
        end
      end
      S_A_WAIT: nxt = S_A_TAG;
      S_A_TAG: begin
        case (tag)
          TAG_FRAME: begin
            c_req = 1'b1; c_addr = mem_rdata; nxt = S_A_SWAIT;
          end
          TAG_REDIR: begin
            if (!hop_at_lim) begin
              hop_step = 1'b1; c_req = 1'b1;
              c_addr = av_addr(redir_idx); nxt = S_A_WAIT;
            end else nxt = S_IDLE;
          end
          default: nxt = S_IDLE;
        endcase
      end
      S_A_SWAIT: nxt = S_A_SUCC;
      S_A_SUCC: begin
        c_req = 1'b1; c_we = 1'b1; c_addr = frame_r; c_wdata = mem_rdata;
        nxt = S_A_HEAD;
      end
      S_A_HEAD: begin
        c_req = 1'b1; c_we = 1'b1; c_addr = av_addr(cur_idx); c_wdata = succ_r;
        nxt = S_FIN;
      end
      S_F_WAIT: nxt = S_F_IDX;
      S_F_IDX: begin
        c_req = 1'b1; c_addr = av_addr(hdr_idx); nxt = S_F_HWAIT;
      end
      S_F_HWAIT: nxt = S_F_HEAD;
      S_F_HEAD: begin
        c_req = 1'b1; c_we = 1'b1; c_addr = av_addr(cur_idx); c_wdata = frame_r;
        nxt = S_F_LINK;
      end
      S_F_LINK: begin
        c_req = 1'b1; c_we = 1'b1; c_addr = frame_r; c_wdata = succ_r;
        nxt = S_FIN;
      end
      S_FIN:   nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      busy      <= 1'b0;
      done      <= 1'b0;
      fault     <= 1'b0;
      fault_idx <= '0;
      frame_out <= '0;
      cur_idx   <= '0;
      orig_idx  <= '0;
      frame_r   <= '0;
      succ_r    <= '0;
    end else begin
      state <= nxt;
      done  <= 1'b0;
      fault <= 1'b0;
      case (state)
        S_IDLE: begin
          if (alloc_go) begin
            busy <= 1'b1; cur_idx <= size_idx_in; orig_idx <= size_idx_in;
          end else if (free_go) begin
            busy <= 1'b1; frame_r <= frame_in;
          end
        end
        S_A_TAG: begin
          if (tag == TAG_FRAME) begin
            frame_r <= mem_rdata;
          end else if (tag == TAG_REDIR && !hop_at_lim) begin
            cur_idx <= redir_idx;
          end else begin
            busy <= 1'b0; done <= 1'b1; fault <= 1'b1; fault_idx <= orig_idx;
          end
        end
        S_A_SUCC: succ_r  <= mem_rdata;
        S_F_IDX:  cur_idx <= hdr_idx;
        S_F_HEAD: succ_r  <= mem_rdata;
        S_FIN: begin
          busy <= 1'b0; done <= 1'b1; frame_out <= frame_r;
        end
        default: ;
      endcase
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && (alloc_go || free_go)) |=> busy);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  // R4
  fault_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> done);

  // R3
  dirty_before_head_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_A_HEAD) |-> (mem_req && mem_we && mem_addr == frame_r && mem_wdata == succ_r));

  // R7
  hop_fault_chk: assert property (@(posedge clk) disable iff (rst)
    (state == S_A_TAG && tag == TAG_REDIR && hop_at_lim) |=> (done && fault && fault_idx == orig_idx));

endmodule

// File: tb/frame_pool_alloc_tb_top.sv
`timescale 1ns/1ps
module frame_pool_alloc_tb_top;
  localparam int W = 12;
  localparam int IW = 4;
  localparam logic [W-1:0] AVB = 12'h100;
  localparam int HOPS = 3;
  localparam logic [W-1:0] EMPTY = 12'h001;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_go = 1'b0, free_go = 1'b0;
  logic [IW-1:0] size_idx_in = '0;
  logic [W-1:0] frame_in = '0;
  logic busy, done, fault;
  logic [IW-1:0] fault_idx;
  logic [W-1:0] frame_out;
  logic mem_req, mem_we;
  logic [W-1:0] mem_addr, mem_wdata;
  logic [W-1:0] mem_rdata = '0;

  logic [W-1:0] mem [0:4095];
  logic bk_we = 1'b0;
  logic [W-1:0] bk_addr = '0, bk_data = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  logic          lg_we [0:15];
  logic [W-1:0]  lg_a  [0:15];
  logic [W-1:0]  lg_d  [0:15];
  int lg_n = 0;

  logic [W-1:0] stk [0:63];
  int sp = 0;
  int pool = 0;

  always #4 clk = ~clk;

  frame_pool_alloc dut_i (
    .clk(clk), .rst(rst), .alloc_go(alloc_go), .free_go(free_go),
    .size_idx_in(size_idx_in), .frame_in(frame_in), .busy(busy), .done(done),
    .fault(fault), .fault_idx(fault_idx), .frame_out(frame_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    else if (bk_we) mem[bk_addr] <= bk_data;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  always @(negedge clk) begin
    if (mem_req && lg_n < 16) begin
      lg_we[lg_n] = mem_we; lg_a[lg_n] = mem_addr; lg_d[lg_n] = mem_wdata;
      lg_n = lg_n + 1;
    end
  end

  task automatic chk(input string rq, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [W-1:0] a, input logic [W-1:0] d);
    @(negedge clk); bk_we = 1'b1; bk_addr = a; bk_data = d;
    @(negedge clk); bk_we = 1'b0;
  endtask

  function automatic logic [W-1:0] hd(input int idx);
    return AVB | W'(idx);
  endfunction

  task automatic clear_heads();
    for (int i = 0; i < 16; i++) wr(hd(i), EMPTY);
  endtask

  task automatic make_list(input int idx, input int n);
    logic [W-1:0] nxtp = mem[hd(idx)];
    for (int k = 0; k < n; k++) begin
      logic [W-1:0] f = W'(12'h204 + 16 * pool);
      pool++;
      wr(f - 12'd4, W'(idx));
      wr(f, nxtp);
      nxtp = f;
    end
    wr(hd(idx), nxtp);
  endtask

  function automatic void ref_alloc(input int idx, output bit flt,
                                    output logic [W-1:0] fr, output int fin);
    int cur = idx;
    bit fin_walk = 1'b0;
    flt = 1'b0; fr = '0; fin = idx;
    for (int h = 0; h <= HOPS + 1 && !fin_walk; h++) begin
      logic [W-1:0] w = mem[hd(cur)];
      case (w[1:0])
        2'd0: begin fr = w; fin = cur; fin_walk = 1'b1; end
        2'd2: begin
          if (h == HOPS) begin flt = 1'b1; fin_walk = 1'b1; end
          else cur = int'(w[5:2]);
        end
        default: begin flt = 1'b1; fin_walk = 1'b1; end
      endcase
    end
  endfunction

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1 && n < 200) begin @(negedge clk); n++; end
    if (n >= 200) begin n_chk++; n_fail++; $display("FAIL R9: no done, got 0 expected 1"); end
  endtask

  task automatic start(input bit a, input bit f, input int idx, input logic [W-1:0] fr);
    lg_n = 0;
    @(negedge clk);
    alloc_go = a; free_go = f; size_idx_in = IW'(idx); frame_in = fr;
    @(negedge clk);
    alloc_go = 1'b0; free_go = 1'b0;
  endtask

  // full allocation check against the bench walk
  task automatic do_alloc(input int idx, input string rq, output logic [W-1:0] got);
    bit flt; logic [W-1:0] fr, succ; int fin;
    ref_alloc(idx, flt, fr, fin);
    succ = flt ? '0 : mem[fr];
    start(1'b1, 1'b0, idx, '0);
    wait_done();
    got = frame_out;
    chk({rq, " R1 first read"}, lg_a[0], hd(idx));
    chk({rq, " fault"}, W'(fault), W'(flt));
    if (flt) begin
      chk({rq, " R4 fault_idx"}, W'(fault_idx), W'(idx));
      chk({rq, " R4 no write"}, W'(lg_n > 0 && lg_we[lg_n-1]), '0);
    end else begin
      chk({rq, " R2 frame"}, frame_out, fr);
      chk({rq, " R2 head"}, mem[hd(fin)], succ);
      chk({rq, " R3 link kept"}, mem[fr], succ);
      chk({rq, " R3 write cnt"}, W'(lg_n >= 2 ? (lg_we[lg_n-2] && lg_we[lg_n-1] && !lg_we[lg_n-3]) : 1'b0), 12'd1);
      chk({rq, " R3 dirty first"}, lg_a[lg_n-2], fr);
      chk({rq, " R3 head second"}, lg_a[lg_n-1], hd(fin));
      if (sp < 64) begin stk[sp] = fr; sp++; end
    end
  endtask

  task automatic do_free(input logic [W-1:0] fr, input string rq);
    int idx = int'(mem[fr - 12'd4] & 12'h00f);
    logic [W-1:0] old = mem[hd(idx)];
    start(1'b0, 1'b1, 0, fr);
    wait_done();
    chk({rq, " R8 hdr read"}, lg_a[0], fr - 12'd4);
    chk({rq, " R8 new head"}, mem[hd(idx)], fr);
    chk({rq, " R8 link"}, mem[fr], old);
    chk({rq, " R8 no fault"}, W'(fault), '0);
  endtask

  initial begin
    logic [W-1:0] g, c, e, d;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", W'(busy), '0);
    chk("R11 done", W'(done), '0);
    chk("R11 fault", W'(fault), '0);
    chk("R11 mem_req", W'(mem_req), '0);

    clear_heads();
    make_list(5, 2);
    do_alloc(5, "d1", g);
    do_alloc(5, "d2", g);
    do_alloc(5, "d3 R4 empty", g);
    // R5 undefined tag
    wr(hd(7), 12'h003);
    do_alloc(7, "d4 R5 undef", g);
    chk("R5 idx", W'(fault_idx), 12'd7);
    // R6 forwarding one hop
    wr(hd(9), (12'd5 << 2) | 12'd2);
    make_list(5, 1);
    do_alloc(9, "d5 R6", c);
    chk("R6 fwd kept", mem[hd(9)], (12'd5 << 2) | 12'd2);
    chk("R6 target empty", mem[hd(5)], EMPTY);
    do_alloc(9, "d6 R6 fault", g);
    chk("R6 orig idx", W'(fault_idx), 12'd9);
    // R7 chain exactly at limit, beyond limit, and a cycle
    wr(hd(10), (12'd11 << 2) | 12'd2);
    wr(hd(11), (12'd12 << 2) | 12'd2);
    wr(hd(12), (12'd13 << 2) | 12'd2);
    make_list(13, 1);
    do_alloc(10, "d7 R7 at limit", g);
    chk("R7 at limit ok", W'(fault), '0);
    wr(hd(0), (12'd1 << 2) | 12'd2);
    wr(hd(1), (12'd2 << 2) | 12'd2);
    wr(hd(2), (12'd3 << 2) | 12'd2);
    wr(hd(3), (12'd4 << 2) | 12'd2);
    make_list(4, 1);
    do_alloc(0, "d8 R7 over", g);
    chk("R7 over fault", W'(fault), 12'd1);
    wr(hd(14), (12'd15 << 2) | 12'd2);
    wr(hd(15), (12'd14 << 2) | 12'd2);
    do_alloc(14, "d9 R7 cycle", g);
    chk("R7 cycle idx", W'(fault_idx), 12'd14);
    // R8 release then reuse
    do_free(c, "d10");
    do_alloc(5, "d11 R8 reuse", g);
    chk("R8 reused frame", g, c);
    // R9 inputs while busy are ignored
    wr(hd(6), EMPTY);
    make_list(8, 2);
    e = mem[hd(8)];
    lg_n = 0;
    @(negedge clk); alloc_go = 1'b1; size_idx_in = 4'd8;
    @(negedge clk); alloc_go = 1'b0;
    @(negedge clk); free_go = 1'b1; frame_in = c; size_idx_in = 4'd6; alloc_go = 1'b1;
    @(negedge clk); free_go = 1'b0; alloc_go = 1'b0;
    wait_done();
    chk("R9 frame", frame_out, e);
    @(negedge clk);
    chk("R9 done pulse", W'(done), '0);
    repeat (3) @(negedge clk);
    chk("R9 no restart", W'(busy), '0);
    chk("R9 list5 untouched", mem[hd(5)], EMPTY);
    chk("R9 list6 untouched", mem[hd(6)], EMPTY);
    // R10 same-cycle allocate and release: allocation wins
    d = mem[hd(8)];
    start(1'b1, 1'b1, 8, c);
    wait_done();
    chk("R10 alloc frame", frame_out, d);
    repeat (2) @(negedge clk);
    chk("R10 free dropped", mem[hd(5)], EMPTY);
    chk("R10 idle", W'(busy), '0);

    // seeded random mix
    for (int b = 0; b < 5; b++) begin
      pool = 0; sp = 0;
      clear_heads();
      for (int i = 0; i < 16; i++) begin
        int r = int'($urandom % 8);
        if (r == 1) wr(hd(i), 12'h003);
        else if (r == 2) wr(hd(i), (W'($urandom % 16) << 2) | 12'd2);
        else if (r >= 3) make_list(i, (r % 3) + 1);
      end
      for (int k = 0; k < 40; k++) begin
        if (sp > 0 && ($urandom % 2) == 1) begin
          sp--;
          do_free(stk[sp], "rnd");
        end else begin
          do_alloc(int'($urandom % 16), "rnd", g);
        end
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule